// File: doc/BRIEF.md
# Parallel EPROM Mode-Decoding Front End

This block models the control side of a 256K x 16 parallel EPROM as a synchronous circuit. Four asynchronous control pins are brought into the system clock domain: chip select and output enable (both active low), a programming-supply flag and a high-voltage flag on address bit 9. The synchronised pins select one of eight operating modes. In these modes the block returns array data, returns identifier codes, releases the bus, or programs a word. The array is a small register memory indexed by the low address bits, and programming can only clear bits in it. A synchronous erase input returns the whole array to all ones, so tests can start again from a blank part.

Outputs are registered. `data_oe_o` is the tri-state enable for the pad driver. When the enable is off, `data_o` is held at zero. `mode_o` reports the decoded mode. Programming data arrives on a separate input, `data_i`. The address and data inputs are treated as quasi-static: they are not synchronised.

Top module: `eprom_ctrl_top`

## Requirements
- R1: While reset is asserted and after it is released, the array holds all ones in every word. With select and enable inactive, the block reports `mode_o` = 0 (standby), `data_oe_o` = 0 and `data_o` = 0.
- R2: With supply flag low, high-voltage flag low, select low and enable low, `mode_o` = 1 and the bus drives the word stored at index `addr_i[5:0]`. Address bits above the index do not change which word is read.
- R3: When the bus is not driven, `data_o` is zero. With supply flag low, select low and enable high, `mode_o` = 2 and the bus is off. With supply flag high and select and enable both low, `mode_o` = 2 and the bus is off.
- R4: With supply flag low and select high, `mode_o` = 0 and the bus is off, whatever the enable pin is.
- R5: With supply flag low, high-voltage flag high, select and enable low, and every address bit except bits 0 and 9 at zero, `mode_o` = 6. The bus drives 0x0020 when bit 0 is 0 and 0x0044 when bit 0 is 1. Bit 9 may be 0 or 1.
- R6: Under the same conditions as R5 but with any other address bit set, `mode_o` = 7 and the bus drives 0x0000.
- R7: With supply flag high, enable high and select low, `mode_o` = 3 and the bus is off. A rising edge of the synchronised select signal, seen while supply is high and enable is high, writes one word at the addressed index. A select rise while enable is low writes nothing.
- R8: A write stores old AND new, so a bit already at 0 stays at 0 even when the written word has a 1 in that position.
- R9: With supply flag high, select high and enable low, `mode_o` = 4 and the bus drives the addressed word.
- R10: With supply flag high, select high and enable high, `mode_o` = 5, the bus is off, and changes on the data input write nothing.
- R11: A one-cycle pulse on `erase_all_i` returns every word to all ones.
- R12: A change on a control pin made between clock edges reaches the outputs after the third rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 18 | Word address |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| vpp_hi_i | input | 1 | Programming supply present |
| a9_hv_i | input | 1 | High voltage present on address bit 9 |
| data_i | input | 16 | Word to program |
| erase_all_i | input | 1 | Synchronous erase of the whole array |
| data_o | output | 16 | Output word, zero when not driven |
| data_oe_o | output | 1 | Tri-state enable for the data pads |
| mode_o | output | 3 | Decoded operating mode |

## Verification
The hardest states to reach from the ports are the program-gating corners. These are a select rise while the enable is low, a select that stays high in inhibit while the data input changes, and the first select rise after the supply flag comes up. In each case the only visible effect is that nothing changes, so the bench reads the word back in verify mode before and after and compares it against a shadow array. The bench also programs every index with a distinct pattern and then re-programs words with ones, to show that bits only ever clear. It sweeps all sixteen control combinations, and it walks a single set bit across every address position in signature mode.

// File: rtl/eprom_pkg.sv
`timescale 1ns/1ps
package eprom_pkg;
  typedef enum logic [2:0] {
    MODE_STANDBY = 3'd0,
    MODE_READ    = 3'd1,
    MODE_OUT_DIS = 3'd2,
    MODE_PROGRAM = 3'd3,
    MODE_VERIFY  = 3'd4,
    MODE_INHIBIT = 3'd5,
    MODE_SIG     = 3'd6,
    MODE_SIG_BAD = 3'd7
  } mode_e;

  localparam logic [7:0] SIG_MFR_CODE = 8'h20;
  localparam logic [7:0] SIG_DEV_CODE = 8'h44;

  function automatic logic mode_drives(mode_e m);
    return (m == MODE_READ) || (m == MODE_VERIFY) ||
           (m == MODE_SIG)  || (m == MODE_SIG_BAD);
  endfunction
endpackage

// File: rtl/eprom_sync.sv
`timescale 1ns/1ps
module eprom_sync #(
  parameter int unsigned   W       = 1,
  parameter int unsigned   STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/eprom_mode_dec.sv
`timescale 1ns/1ps
module eprom_mode_dec
  import eprom_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned SIG_BIT = 9
) (
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              vpp_hi_i,
  input  logic              a9_hv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output mode_e             mode_o
);
  // bits allowed to be nonzero during signature read
  localparam logic [ADDR_W-1:0] SIG_FREE = ADDR_W'(1) | (ADDR_W'(1) << SIG_BIT);

  logic sig_addr_ok;
  assign sig_addr_ok = ((addr_i & ~SIG_FREE) == '0);

  always_comb begin
    mode_o = MODE_OUT_DIS;
    if (!vpp_hi_i) begin
      if (ce_n_i)       mode_o = MODE_STANDBY;
      else if (oe_n_i)  mode_o = MODE_OUT_DIS;
      else if (a9_hv_i) mode_o = sig_addr_ok ? MODE_SIG : MODE_SIG_BAD;
      else              mode_o = MODE_READ;
    end else begin
      unique case ({ce_n_i, oe_n_i})
        2'b01:   mode_o = MODE_PROGRAM;
        2'b10:   mode_o = MODE_VERIFY;
        2'b11:   mode_o = MODE_INHIBIT;
        default: mode_o = MODE_OUT_DIS;
      endcase
    end
  end
endmodule

// File: rtl/eprom_array.sv
`timescale 1ns/1ps
module eprom_array #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      mem_q[g] <= '1;
      else if (erase_i)                                 mem_q[g] <= '1;
      else if (wr_i && (wr_idx_i == IDX_W'(g)))         mem_q[g] <= mem_q[g] & wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/eprom_ctrl_top.sv
`timescale 1ns/1ps
module eprom_ctrl_top
  import eprom_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned SIG_BIT = 9,
  localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              vpp_hi_i,
  input  logic              a9_hv_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              erase_all_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [2:0]        mode_o
);
  // {vpp, a9, oe_n, ce_n}; reset to idle pins
  logic [3:0] ctl_s;
  eprom_sync #(.W(4), .STAGES(2), .RST_VAL(4'b0011)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({vpp_hi_i, a9_hv_i, oe_ni, ce_ni}),
    .q_o   (ctl_s)
  );

  logic vpp_s, a9_s, oe_s, ce_s;
  assign {vpp_s, a9_s, oe_s, ce_s} = ctl_s;

  logic ce_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_q <= 1'b1;
    else         ce_q <= ce_s;
  end

  // program pulse ends: commit on select rise
  logic prog_fire;
  assign prog_fire = ce_s & ~ce_q & oe_s & vpp_s;

  mode_e mode_d;
  eprom_mode_dec #(.ADDR_W(ADDR_W), .SIG_BIT(SIG_BIT)) u_dec (
    .ce_n_i  (ce_s),
    .oe_n_i  (oe_s),
    .vpp_hi_i(vpp_s),
    .a9_hv_i (a9_s),
    .addr_i  (addr_i),
    .mode_o  (mode_d)
  );

  logic [DATA_W-1:0] rd_word;
  eprom_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .erase_i  (erase_all_i),
    .wr_i     (prog_fire),
    .wr_idx_i (addr_i[IDX_W-1:0]),
    .wr_data_i(data_i),
    .rd_idx_i (addr_i[IDX_W-1:0]),
    .rd_data_o(rd_word)
  );

  logic [DATA_W-1:0] data_d;
  always_comb begin
    unique case (mode_d)
      MODE_READ, MODE_VERIFY: data_d = rd_word;
      MODE_SIG:               data_d = DATA_W'(addr_i[0] ? SIG_DEV_CODE : SIG_MFR_CODE);
      default:                data_d = '0;
    endcase
  end

  mode_e             mode_q;
  logic              oe_q;
  logic [DATA_W-1:0] data_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STANDBY;
      oe_q   <= 1'b0;
      data_q <= '0;
    end else begin
      mode_q <= mode_d;
      oe_q   <= mode_drives(mode_d);
      data_q <= data_d;
    end
  end

  assign data_o    = data_q;
  assign data_oe_o = oe_q;
  assign mode_o    = mode_q;
endmodule

// File: rtl/eprom_ctrl_chk.sv
`timescale 1ns/1ps
module eprom_ctrl_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              vpp_hi_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic [2:0]        mode_o,
  input logic              prog_fire
);
  a_r4_standby_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ce_ni,1) && $past(ce_ni,2) && $past(ce_ni,3) &&
     !$past(vpp_hi_i,1) && !$past(vpp_hi_i,2) && !$past(vpp_hi_i,3))
    |-> (!data_oe_o && mode_o == 3'd0));

  a_r3_no_drive_g_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(oe_ni,1) && $past(oe_ni,2) && $past(oe_ni,3)) |-> !data_oe_o);

  a_r3_idle_bus_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));

  a_r5_sig_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd6) |-> (data_oe_o && data_o[DATA_W-1:8] == '0 &&
                          (data_o[7:0] == 8'h20 || data_o[7:0] == 8'h44)));

  a_r7_prog_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_fire |-> ($past(vpp_hi_i,2) && $past(oe_ni,2) && $past(ce_ni,2) && !$past(ce_ni,3)));
endmodule

bind eprom_ctrl_top eprom_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ce_ni    (ce_ni),
  .oe_ni    (oe_ni),
  .vpp_hi_i (vpp_hi_i),
  .data_o   (data_o),
  .data_oe_o(data_oe_o),
  .mode_o   (mode_o),
  .prog_fire(prog_fire)
);

// File: tb/eprom_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module eprom_ctrl_top_tb_top;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] addr = '0;
  logic        ce_n = 1'b1, oe_n = 1'b1, vpp = 1'b0, a9 = 1'b0, erase = 1'b0;
  logic [15:0] din = 16'hFFFF;
  logic [15:0] dout;
  logic        doe;
  logic [2:0]  mode;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] model [DEPTH];

  always #4 clk = ~clk;

  eprom_ctrl_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ce_ni(ce_n), .oe_ni(oe_n),
    .vpp_hi_i(vpp), .a9_hv_i(a9), .data_i(din), .erase_all_i(erase),
    .data_o(dout), .data_oe_o(doe), .mode_o(mode)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_mode(logic v, logic a, logic ce, logic oe, logic [17:0] ad);
    logic ok;
    ok = ((ad & ~18'h00201) == '0);
    if (!v) begin
      if (ce) return 0;
      if (oe) return 2;
      if (a) return ok ? 6 : 7;
      return 1;
    end
    if (!ce && oe) return 3;
    if (ce && !oe) return 4;
    if (ce && oe)  return 5;
    return 2;
  endfunction

  function automatic string req_of(int m);
    case (m)
      0: return "R4";
      1: return "R2";
      2: return "R3";
      3: return "R7";
      4: return "R9";
      5: return "R10";
      6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic program_word(input logic [17:0] a, input logic [15:0] d);
    vpp = 1; a9 = 0; oe_n = 1; ce_n = 1; addr = a; din = d;
    settle();
    ce_n = 0;
    settle();
    chk("R7", "program mode", mode, 3);
    chk("R7", "program bus off", doe, 0);
    ce_n = 1;
    settle();
    model[a[5:0]] = model[a[5:0]] & d;
  endtask

  task automatic verify_word(input string req, input logic [17:0] a);
    vpp = 1; a9 = 0; ce_n = 1; oe_n = 0; addr = a;
    settle();
    chk(req, "verify mode", mode, 4);
    chk(req, "verify data", dout, model[a[5:0]]);
    oe_n = 1;
    settle();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1", "mode in reset", mode, 0);
    chk("R1", "oe in reset", doe, 0);
    rst_n = 1;
    settle();
    chk("R1", "mode after reset", mode, 0);
    chk("R1", "oe after reset", doe, 0);
    chk("R1", "data after reset", dout, 0);

    // blank read of every word (R1, R2)
    ce_n = 0; oe_n = 0;
    for (int i = 0; i < DEPTH; i++) begin
      addr = 18'(i);
      settle();
      chk("R1", "blank word", dout, 16'hFFFF);
    end

    // all 16 control combinations, addr 0, data all ones
    ce_n = 1; oe_n = 1; addr = '0; din = 16'hFFFF;
    for (int c = 0; c < 16; c++) begin
      int em;
      logic [15:0] ed;
      {vpp, a9, ce_n, oe_n} = 4'(c);
      settle();
      em = exp_mode(vpp, a9, ce_n, oe_n, addr);
      ed = (em == 1 || em == 4) ? model[0] : (em == 6 ? 16'h0020 : 16'h0000);
      chk(req_of(em), "sweep mode", mode, em);
      chk(req_of(em), "sweep oe", doe, (em == 1 || em == 4 || em >= 6) ? 1 : 0);
      chk(req_of(em), "sweep data", dout, ed);
    end
    vpp = 0; a9 = 0; ce_n = 1; oe_n = 1;
    settle();

    // program every index with a distinct pattern
    for (int i = 0; i < DEPTH; i++)
      program_word(18'(i), 16'hA5C3 ^ 16'(i * 16'h0111));
    for (int i = 0; i < DEPTH; i++) verify_word("R9", 18'(i));
    // normal read, high address bits set (R2)
    vpp = 0; ce_n = 0; oe_n = 0;
    for (int i = 0; i < DEPTH; i++) begin
      addr = 18'(i) | 18'h2A400;
      settle();
      chk("R2", "read mode", mode, 1);
      chk("R2", "read data", dout, model[i]);
    end
    ce_n = 1; oe_n = 1;

    // only clears (R8)
    program_word(18'd5, 16'hFFFF);
    verify_word("R8", 18'd5);
    program_word(18'd5, 16'h0FF0);
    verify_word("R8", 18'd5);
    program_word(18'd5, ~model[5]);
    verify_word("R8", 18'd5);
    chk("R8", "no bit set", model[5] & ~(16'hA5C3 ^ 16'(5 * 16'h0111)), 0);

    // inhibit: data changes, nothing written (R10)
    vpp = 1; ce_n = 1; oe_n = 1; addr = 18'd7; din = 16'hFFFF;
    settle();
    chk("R10", "inhibit mode", mode, 5);
    chk("R10", "inhibit bus off", doe, 0);
    din = 16'h0000;
    settle();
    din = 16'h1234;
    settle();
    verify_word("R10", 18'd7);

    // select pulse with enable low writes nothing (R7)
    vpp = 1; oe_n = 0; ce_n = 1; addr = 18'd9; din = 16'h0000;
    settle();
    ce_n = 0;
    settle();
    chk("R3", "vpp high E G low off", doe, 0);
    chk("R3", "vpp high E G low mode", mode, 2);
    ce_n = 1;
    settle();
    chk("R7", "no write with G low", dout, model[9]);
    oe_n = 1;
    settle();

    // signature (R5, R6)
    vpp = 0; a9 = 1; ce_n = 0; oe_n = 0;
    for (int k = 0; k < 4; k++) begin
      addr = {8'h0, k[1], 8'h0, k[0]};
      settle();
      chk("R5", "sig mode", mode, 6);
      chk("R5", "sig code", dout, k[0] ? 16'h0044 : 16'h0020);
    end
    for (int b = 1; b < 18; b++) begin
      if (b == 9) continue;
      addr = 18'(1) << b;
      settle();
      chk("R6", "bad sig mode", mode, 7);
      chk("R6", "bad sig data", dout, 0);
      chk("R6", "bad sig oe", doe, 1);
    end
    a9 = 0; ce_n = 1; oe_n = 1;
    settle();

    // erase (R11)
    erase = 1;
    @(negedge clk);
    erase = 0;
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    for (int i = 0; i < DEPTH; i += 7) verify_word("R11", 18'(i));
    vpp = 0;

    // latency (R12)
    ce_n = 0; oe_n = 1; addr = 18'd3;
    settle();
    oe_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R12", "oe after 2 edges", doe, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R12", "oe after 3 edges", doe, 1);
    chk("R12", "data after 3 edges", dout, 16'hFFFF);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule